// File: doc/BRIEF.md
# Power-Fail Access Guard

This block sits between a host's access strobes and a memory-mapped storage device. A digital power-good comparator feeds it, and it decides cycle by cycle whether a strobe may reach the device. When the supply-loss flag rises, an access that was already running is allowed to finish. The block then deselects the device and write-protects it. If the running access lasts too long, a timeout forces protection anyway. A new access that starts after the flag is seen is refused at once.

When the supply returns, the block keeps the device protected for a further recovery interval before it passes strobes again. Both intervals are parameters counted in clock cycles, and one shared down-counter times them.

A separate output tells the power switch to run the storage domain from the battery while the supply sits below the switchover level. This output stays low until the supply has been seen above that level at least once after reset, which models the factory isolation of the cell.

Top module: `pwr_guard`

## Requirements
- R1: While reset is held, and after reset until recovery completes, core_sel, core_wr and core_drive are low whatever the host strobes are, and batt_sel is low.
- R2: In normal operation the outputs follow the strobes in the same cycle: core_sel = host_sel, core_wr = host_sel and host_wr, core_drive = host_sel and host_rd and not host_wr.
- R3: If host_sel was low on the clock edge before the first cycle in which pwr_fail is high, an access raised in that cycle is blocked at once.
- R4: An access that is running when pwr_fail first rises (host_sel high on the previous edge and still high) keeps passing until host_sel falls. From then on the device is protected, and raising host_sel again is refused.
- R5: A running access that is held passes in the cycle pwr_fail is first seen and for exactly WPT_CYC further cycles. After that it is blocked.
- R6: While protected, core_sel, core_wr and core_drive stay low for every combination of the host strobes.
- R7: After pwr_fail falls, strobes are refused until the (REC_CYC+1)-th rising clock edge that samples pwr_fail low. From that edge on they pass.
- R8: If pwr_fail rises during recovery, the block returns to protection. A later fall restarts the full recovery interval.
- R9: batt_sel is low until below_swo has been sampled low on a clock edge after reset. From then on batt_sel equals below_swo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models the factory state |
| host_sel | input | 1 | Host device-select strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_rd | input | 1 | Host read / output-enable strobe, active high |
| pwr_fail | input | 1 | Supply below power-fail threshold, active high |
| below_swo | input | 1 | Supply below battery switchover level, active high |
| core_sel | output | 1 | Gated select to the storage device |
| core_wr | output | 1 | Gated write enable to the storage device |
| core_drive | output | 1 | Enable for the device's data output drivers |
| batt_sel | output | 1 | Run storage domain from battery |

## Verification
The assertions assume that the comparator flags are already synchronous to clk, and that below_swo is never high while pwr_fail is low. The stimulus changes every input only on the falling clock edge. It raises below_swo only while pwr_fail is already high. The timed windows are checked against the small interval values that the bench chooses, and the bench sweeps the release point of the running access across the whole timeout window and one cycle past it.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

    typedef enum logic [1:0] {
        PS_GUARD   = 2'd0,
        PS_RECOVER = 2'd1,
        PS_OPEN    = 2'd2,
        PS_DRAIN   = 2'd3
    } pstate_e;

    typedef struct packed {
        pstate_e state;
        logic    sel_prev;
    } fsm_t;

endpackage

// File: rtl/pwp_timer.sv
module pwp_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pwp_gate.sv
module pwp_gate (
    input  logic allow,
    input  logic host_sel,
    input  logic host_wr,
    input  logic host_rd,
    output logic core_sel,
    output logic core_wr,
    output logic core_drive
);

    always_comb begin
        core_sel   = allow & host_sel;
        core_wr    = allow & host_sel & host_wr;
        // drivers stay off while a write is active to avoid contention
        core_drive = allow & host_sel & host_rd & ~host_wr;
    end

endmodule

// File: rtl/pwp_batt.sv
module pwp_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic below_swo,
    output logic batt_sel,
    output logic armed
);

    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q | ~below_swo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign armed    = armed_q;
    assign batt_sel = armed_q & below_swo;

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
    parameter int unsigned WPT_CYC = 10000,
    parameter int unsigned REC_CYC = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_sel,
    input  logic host_wr,
    input  logic host_rd,
    input  logic pwr_fail,
    input  logic below_swo,
    output logic core_sel,
    output logic core_wr,
    output logic core_drive,
    output logic batt_sel
);

    import pwp_pkg::*;

    localparam int unsigned MAXC  = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WPT_LD = CNT_W'(WPT_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    fsm_t             cur_q, nxt_d;
    logic             allow;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_zero;
    logic             batt_armed;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.sel_prev = host_sel;
        allow          = 1'b0;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        case (cur_q.state)
            PS_GUARD: begin
                if (!pwr_fail) begin
                    nxt_d.state = PS_RECOVER;
                    tmr_load    = 1'b1;
                    tmr_val     = REC_LD;
                end
            end
            PS_RECOVER: begin
                if (pwr_fail) begin
                    nxt_d.state = PS_GUARD;
                end else if (tmr_zero) begin
                    nxt_d.state = PS_OPEN;
                end
            end
            PS_OPEN: begin
                if (!pwr_fail) begin
                    allow = 1'b1;
                end else if (cur_q.sel_prev && host_sel) begin
                    // access already running: let it drain under timeout
                    allow       = 1'b1;
                    nxt_d.state = PS_DRAIN;
                    tmr_load    = 1'b1;
                    tmr_val     = WPT_LD;
                end else begin
                    nxt_d.state = PS_GUARD;
                end
            end
            PS_DRAIN: begin
                allow = 1'b1;
                if (!host_sel || tmr_zero) begin
                    nxt_d.state = PS_GUARD;
                end
            end
            default: nxt_d.state = PS_GUARD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= PS_GUARD;
            cur_q.sel_prev <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    pwp_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    pwp_gate i_gate (
        .allow      (allow),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .core_sel   (core_sel),
        .core_wr    (core_wr),
        .core_drive (core_drive)
    );

    pwp_batt i_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_swo (below_swo),
        .batt_sel  (batt_sel),
        .armed     (batt_armed)
    );

    a_r6_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == PS_GUARD) |-> (!core_sel && !core_wr && !core_drive));

    a_r7_recover_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == PS_RECOVER) |-> !core_sel);

    a_r7_open_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == PS_OPEN && $past(cur_q.state) == PS_RECOVER)
            |-> ($past(tmr_zero) && !$past(pwr_fail)));

    a_r5_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == PS_DRAIN) |-> (32'(tmr_cnt) < WPT_CYC));

    a_r4_drain_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == PS_DRAIN && $past(cur_q.state) == PS_OPEN)
            |-> ($past(host_sel) && $past(pwr_fail)));

    a_r2_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |-> (host_wr && host_sel));

    a_r9_batt_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> (below_swo && batt_armed));

endmodule

// File: tb/test_pwr_guard.sv
module test_pwr_guard;

    localparam int unsigned WPT = 4;
    localparam int unsigned REC = 6;

    logic clk = 1'b0;
    logic rst_n, host_sel, host_wr, host_rd, pwr_fail, below_swo;
    logic core_sel, core_wr, core_drive, batt_sel;
    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    pwr_guard #(.WPT_CYC(WPT), .REC_CYC(REC)) i_pwr_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .pwr_fail   (pwr_fail),
        .below_swo  (below_swo),
        .core_sel   (core_sel),
        .core_wr    (core_wr),
        .core_drive (core_drive),
        .batt_sel   (batt_sel)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic recover_check(input string tag);
        for (int k = 1; k <= int'(REC) + 1; k++) begin
            step();
            #1 chk(tag, core_sel, (k == int'(REC) + 1));
        end
    endtask

    task automatic go_open();
        pwr_fail = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        repeat (REC + 2) step();
        host_sel = 1'b1; host_wr = 1'b1;
        step();
    endtask

    initial begin
        rst_n = 1'b0; pwr_fail = 1'b1; below_swo = 1'b1;
        host_sel = 1'b1; host_wr = 1'b1; host_rd = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 sel in reset", core_sel, 1'b0);
        chk("R1 wr in reset", core_wr, 1'b0);
        chk("R1 drive in reset", core_drive, 1'b0);
        chk("R9 batt before first supply", batt_sel, 1'b0);
        rst_n = 1'b1;
        repeat (3) step();
        #1;
        chk("R1 sel after reset", core_sel, 1'b0);
        chk("R9 batt still isolated", batt_sel, 1'b0);

        below_swo = 1'b0;
        step();
        below_swo = 1'b1;
        #1 chk("R9 batt after arming", batt_sel, 1'b1);
        step();
        below_swo = 1'b0;
        #1 chk("R9 batt follows level", batt_sel, 1'b0);

        host_sel = 1'b1; host_wr = 1'b0; host_rd = 1'b0;
        pwr_fail = 1'b0;
        #1 chk("R7 still guarded", core_sel, 1'b0);
        recover_check("R7 recovery window");

        for (int v = 0; v < 8; v++) begin
            host_sel = v[0]; host_wr = v[1]; host_rd = v[2];
            #1;
            chk("R2 sel", core_sel, v[0]);
            chk("R2 wr", core_wr, v[0] & v[1]);
            chk("R2 drive", core_drive, v[0] & v[2] & ~v[1]);
            step();
        end

        host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        step();
        pwr_fail = 1'b1; host_sel = 1'b1; host_wr = 1'b1;
        #1;
        chk("R3 new access sel", core_sel, 1'b0);
        chk("R3 new access wr", core_wr, 1'b0);
        step();
        #1 chk("R3 stays blocked", core_sel, 1'b0);

        for (int d = 1; d <= int'(WPT) + 2; d++) begin
            go_open();
            pwr_fail = 1'b1;
            #1;
            chk("R4 running access sel", core_sel, 1'b1);
            chk("R4 running access wr", core_wr, 1'b1);
            for (int j = 1; j <= d; j++) begin
                step();
                #1 chk("R5 timeout window", core_sel, (j <= int'(WPT)));
            end
            host_sel = 1'b0;
            #1 chk("R4 access ended", core_sel, 1'b0);
            step();
            host_sel = 1'b1;
            #1 chk("R4 reassert refused", core_sel, 1'b0);
            step();
            #1 chk("R6 protected", core_sel, 1'b0);
        end

        for (int v = 0; v < 8; v++) begin
            host_sel = v[0]; host_wr = v[1]; host_rd = v[2];
            #1;
            chk("R6 sel", core_sel, 1'b0);
            chk("R6 wr", core_wr, 1'b0);
            chk("R6 drive", core_drive, 1'b0);
            step();
        end

        host_sel = 1'b1; host_wr = 1'b0; host_rd = 1'b0;
        pwr_fail = 1'b0;
        repeat (3) step();
        #1 chk("R8 mid recovery", core_sel, 1'b0);
        pwr_fail = 1'b1;
        step();
        pwr_fail = 1'b0;
        #1 chk("R8 back to guard", core_sel, 1'b0);
        recover_check("R8 recovery restart");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule